// File: doc/BRIEF.md
# Byte-Serial Accumulator Access Port

This block holds the 40-bit running sum of an arithmetic accelerator. A CPU reaches the sum through one 8-bit register location at address D5h. Each completed multiply or divide result arriving on the result input is added into the sum. Completed shift and normalize results are ignored. Software reads the sum as five bytes with the most significant byte first. It loads the sum as bytes with the least significant byte first. A short load of the low bytes is valid when the upper bytes are already zero.

A read byte pointer and a write byte pointer track the position in each sequence. Two control inputs clear everything: the sum, the overflow flag, both pointers and any pending result. Five writes of 00h also zero the sum.

A two-state controller handles a byte write that lands in the same cycle as a result. `ST_IDLE` is the normal state. `IDLE_TO_DEFER` fires on a write together with a multiply or divide result: the write is applied and the result is parked. `ST_DEFER` adds the parked result on the next cycle with no write, through `DEFER_TO_IDLE`. `DEFER_HOLD` keeps it parked while further writes arrive. A clear forces `ST_IDLE` from either state through `ANY_TO_IDLE_CLR`.

Top module: `acc_bport`

## Requirements
- R1: After reset the sum is zero, `rd_data` shows 00h and `ovf` is 0.
- R2: `reg_wr` and `reg_rd` act only when `reg_addr` equals D5h. At any other address they change neither the sum nor either pointer.
- R3: `rd_data` shows the sum byte selected by the read pointer. Pointer 0 selects bits 39:32 and pointer 4 selects bits 7:0. Each read advances the pointer by one, and it wraps from 4 to 0.
- R4: Each write replaces only the byte selected by the write pointer. Pointer 0 selects bits 7:0 and pointer 4 selects bits 39:32. The pointer advances by one and wraps from 4 to 0, so writing two bytes onto a zero sum loads a 16-bit value.
- R5: A write returns the read pointer to 0, and a read returns the write pointer to 0. A read and a write in the same cycle act as a write only.
- R6: A result with `res_op` 0 (multiply) or 1 (divide) and `res_valid` high is added to the sum modulo 2^40. A carry out of bit 39 sets `ovf`, which stays set until a clear.
- R7: A result with `res_op` 2 (shift) or 3 (normalize) leaves the sum unchanged.
- R8: When a write and a multiply or divide result come in the same cycle, the write is applied first and the result is added on the next cycle with no write. Results must be at least two cycles apart.
- R9: `clr_mode` or `clr_start` high at a clock edge zeroes the sum and `ovf`, returns both pointers to 0 and drops any pending result. A clear takes priority over all other inputs.
- R10: Five successive writes of 00h from write pointer 0 leave all 40 bits at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 8 | Register address |
| wr_data | input | 8 | Write byte |
| rd_data | output | 8 | Byte at the read pointer |
| clr_mode | input | 1 | Clear control bit, mode side |
| clr_start | input | 1 | Clear control bit, start side |
| res_valid | input | 1 | Result strobe, one cycle |
| res_op | input | 2 | Result kind: 0 multiply, 1 divide, 2 shift, 3 normalize |
| res_data | input | 40 | Result value |
| ovf | output | 1 | Sticky carry out of bit 39 |

## Verification
`rd_data` and `ovf` are driven combinationally from registers. A write, read, clear or direct result taken at rising edge k therefore shows at the outputs before edge k+1. A result parked by a colliding write shows one edge later, before edge k+2. The bench drives inputs on the falling edge and compares both outputs 1 ns later. Its model is advanced right after each rising edge, so every comparison falls inside the cycle in which the value is due. Directed sequences check hand-computed sums for ordering, partial loads, the collision deferral, overflow and each clear. Seeded random traffic is compared against the model on every cycle.

// File: rtl/accp_pkg.sv
package accp_pkg;
    typedef enum logic [1:0] {
        OP_MUL = 2'd0,
        OP_DIV = 2'd1,
        OP_SHF = 2'd2,
        OP_NRM = 2'd3
    } op_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_DEFER = 1'b1
    } st_e;
endpackage

// File: rtl/acc_byte_ptr.sv
module acc_byte_ptr #(
    parameter int NUM = 5,
    parameter int W   = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         step,
    output logic [W-1:0] ptr
);
    localparam logic [W-1:0] LAST = W'(NUM - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (clr) begin
            ptr <= '0;
        end else if (step) begin
            ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
        end
    end
endmodule

// File: rtl/acc_sum_unit.sv
module acc_sum_unit #(
    parameter int W = 40
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] sum,
    output logic         carry
);
    assign {carry, sum} = {1'b0, a} + {1'b0, b};
endmodule

// File: rtl/acc_bport.sv
module acc_bport
    import accp_pkg::*;
#(
    parameter int          ACC_W    = 40,
    parameter int          BYTE_W   = 8,
    parameter logic [7:0]  REG_ADDR = 8'hD5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [BYTE_W-1:0] rd_data,
    input  logic              clr_mode,
    input  logic              clr_start,
    input  logic              res_valid,
    input  logic [1:0]        res_op,
    input  logic [ACC_W-1:0]  res_data,
    output logic              ovf
);
    localparam int NBYTES = ACC_W / BYTE_W;
    localparam int PTR_W  = $clog2(NBYTES);

    st_e               state_q, state_d;
    logic [ACC_W-1:0]  acc_q, pend_q, acc_wr, add_b, sum;
    logic              ovf_q, carry;
    logic [PTR_W-1:0]  rd_ptr, wr_ptr;
    logic              clear, wr_hit, rd_hit, acc_en, do_add, park;

    assign clear  = clr_mode | clr_start;
    assign wr_hit = reg_wr && (reg_addr == REG_ADDR);
    assign rd_hit = reg_rd && (reg_addr == REG_ADDR) && !wr_hit;
    assign acc_en = res_valid && ((op_e'(res_op) == OP_MUL) || (op_e'(res_op) == OP_DIV));
    assign park   = (state_q == ST_IDLE) && wr_hit && acc_en;
    assign do_add = !wr_hit && ((state_q == ST_DEFER) || acc_en);
    assign add_b  = (state_q == ST_DEFER) ? pend_q : res_data;

    acc_byte_ptr #(.NUM(NBYTES), .W(PTR_W)) u_rd_ptr (
        .clk(clk), .rst_n(rst_n), .clr(clear | wr_hit), .step(rd_hit), .ptr(rd_ptr)
    );

    acc_byte_ptr #(.NUM(NBYTES), .W(PTR_W)) u_wr_ptr (
        .clk(clk), .rst_n(rst_n), .clr(clear | rd_hit), .step(wr_hit), .ptr(wr_ptr)
    );

    acc_sum_unit #(.W(ACC_W)) u_sum (
        .a(acc_q), .b(add_b), .sum(sum), .carry(carry)
    );

    // byte replace at the write pointer, byte select at the read pointer
    always_comb begin
        acc_wr  = acc_q;
        rd_data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            if (wr_ptr == PTR_W'(i)) acc_wr[i*BYTE_W +: BYTE_W] = wr_data;
            if (rd_ptr == PTR_W'(NBYTES - 1 - i)) rd_data = acc_q[i*BYTE_W +: BYTE_W];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (clear) begin
            state_d = ST_IDLE;                          // ANY_TO_IDLE_CLR
        end else begin
            unique case (state_q)
                ST_IDLE:  if (park)    state_d = ST_DEFER; // IDLE_TO_DEFER
                ST_DEFER: if (!wr_hit) state_d = ST_IDLE;  // DEFER_TO_IDLE, else DEFER_HOLD
                default:               state_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_q  <= '0;
            pend_q <= '0;
            ovf_q  <= 1'b0;
        end else if (clear) begin
            acc_q  <= '0;
            pend_q <= '0;
            ovf_q  <= 1'b0;
        end else begin
            if (park) pend_q <= res_data;
            if (wr_hit) begin
                acc_q <= acc_wr;
            end else if (do_add) begin
                acc_q <= sum;
                if (carry) ovf_q <= 1'b1;
            end
        end
    end

    assign ovf = ovf_q;
endmodule

// File: rtl/acc_bport_chk.sv
module acc_bport_chk
    import accp_pkg::*;
#(
    parameter int ACC_W  = 40,
    parameter int BYTE_W = 8,
    parameter int PTR_W  = 3,
    parameter int NBYTES = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              clear,
    input logic              wr_hit,
    input logic              rd_hit,
    input logic              acc_en,
    input logic              res_valid,
    input logic [1:0]        res_op,
    input st_e               state_q,
    input logic [ACC_W-1:0]  acc_q,
    input logic [PTR_W-1:0]  rd_ptr,
    input logic [PTR_W-1:0]  wr_ptr,
    input logic              ovf,
    input logic [BYTE_W-1:0] rd_data
);
    // R9
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (rd_data == '0 && !ovf && rd_ptr == '0 && wr_ptr == '0));

    // R7
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_op[1] && !wr_hit && !clear && state_q == ST_IDLE) |=> $stable(acc_q));

    // R8
    defer_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && wr_hit && acc_en && !clear) |=> (state_q == ST_DEFER));

    // R6
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clear) |=> ovf);

    // R5
    rd_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !clear) |=> (rd_ptr == '0));

    // R5
    wr_rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_hit && !clear) |=> (wr_ptr == '0));

    // R3
    ptr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ptr < PTR_W'(NBYTES)) && (wr_ptr < PTR_W'(NBYTES)));

    // R2
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_hit && !rd_hit && !clear && !acc_en && state_q == ST_IDLE)
        |=> ($stable(acc_q) && $stable(rd_ptr) && $stable(wr_ptr)));
endmodule

bind acc_bport acc_bport_chk #(
    .ACC_W(ACC_W), .BYTE_W(BYTE_W), .PTR_W(PTR_W), .NBYTES(NBYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .clear(clear), .wr_hit(wr_hit), .rd_hit(rd_hit),
    .acc_en(acc_en), .res_valid(res_valid), .res_op(res_op), .state_q(state_q),
    .acc_q(acc_q), .rd_ptr(rd_ptr), .wr_ptr(wr_ptr), .ovf(ovf), .rd_data(rd_data)
);

// File: tb/acc_bport_tb_top.sv
`timescale 1ns/1ps
module acc_bport_tb_top;
    localparam logic [7:0] ADR = 8'hD5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 0, reg_rd = 0, clr_mode = 0, clr_start = 0, res_valid = 0;
    logic [7:0]  reg_addr = 8'h00, wr_data = 8'h00;
    logic [1:0]  res_op = 2'd0;
    logic [39:0] res_data = '0;
    logic [7:0]  rd_data;
    logic        ovf;

    int errors = 0, checks = 0;
    bit done = 0;

    logic [39:0] m_acc = '0, m_pend = '0;
    int          m_rp = 0, m_wp = 0;
    bit          m_ovf = 0, m_def = 0;
    logic [7:0]  last_rd;

    always #5 clk = ~clk;

    acc_bport dut_i (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .wr_data(wr_data), .rd_data(rd_data), .clr_mode(clr_mode), .clr_start(clr_start),
        .res_valid(res_valid), .res_op(res_op), .res_data(res_data), .ovf(ovf)
    );

    function automatic logic [7:0] m_byte();
        return 8'((m_acc >> ((4 - m_rp) * 8)) & 40'hFF);
    endfunction

    function automatic void m_add(input logic [39:0] x);
        logic [40:0] s;
        s = {1'b0, m_acc} + {1'b0, x};
        m_acc = s[39:0];
        if (s[40]) m_ovf = 1;
    endfunction

    task automatic check(input string tag, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic cyc(input bit wr, input bit rd, input logic [7:0] addr, input logic [7:0] d,
                       input bit rv, input logic [1:0] op, input logic [39:0] r,
                       input bit cm, input bit cs);
        bit hw, hr, en;
        @(negedge clk);
        reg_wr = wr; reg_rd = rd; reg_addr = addr; wr_data = d;
        res_valid = rv; res_op = op; res_data = r; clr_mode = cm; clr_start = cs;
        #1;
        last_rd = rd_data;
        check("R3 rd_data", 40'(rd_data), 40'(m_byte()));
        check("R6 ovf", 40'(ovf), 40'(m_ovf));
        @(posedge clk);
        hw = wr && addr == ADR;
        hr = rd && addr == ADR && !hw;
        en = rv && op < 2;
        if (cm || cs) begin
            m_acc = '0; m_ovf = 0; m_rp = 0; m_wp = 0; m_def = 0;
        end else if (hw) begin
            m_acc = (m_acc & ~(40'hFF << (m_wp * 8))) | (40'(d) << (m_wp * 8));
            m_wp = (m_wp == 4) ? 0 : m_wp + 1;
            m_rp = 0;
            if (!m_def && en) begin m_def = 1; m_pend = r; end
        end else begin
            if (hr) begin m_rp = (m_rp == 4) ? 0 : m_rp + 1; m_wp = 0; end
            if (m_def) begin m_add(m_pend); m_def = 0; end
            else if (en) m_add(r);
        end
    endtask

    task automatic idle();                     cyc(0,0,ADR,0,0,0,0,0,0); endtask
    task automatic wrb(input logic [7:0] d);   cyc(1,0,ADR,d,0,0,0,0,0); endtask
    task automatic res(input logic [1:0] op, input logic [39:0] r); cyc(0,0,ADR,0,1,op,r,0,0); endtask

    task automatic read_all(output logic [39:0] v);
        v = '0;
        for (int i = 0; i < 5; i++) begin
            cyc(0,1,ADR,0,0,0,0,0,0);
            v = {v[31:0], last_rd};
        end
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [39:0] v;
        int seed;
        bit prev_rv;
        seed = 1234;
        void'($urandom(seed));
        #23 rst_n = 1;
        #1;
        check("R1 rd_data reset", 40'(rd_data), 40'h0);
        check("R1 ovf reset", 40'(ovf), 40'h0);

        wrb(8'h11); wrb(8'h22); wrb(8'h33); wrb(8'h44); wrb(8'h55);
        read_all(v); check("R4 R3 byte order", v, 40'h5544332211);

        cyc(1,0,8'hD4,8'hAA,0,0,0,0,0);
        cyc(0,1,8'hD6,0,0,0,0,0,0);
        read_all(v); check("R2 other address", v, 40'h5544332211);

        cyc(0,1,ADR,0,0,0,0,0,0); cyc(0,1,ADR,0,0,0,0,0,0);
        wrb(8'h99);
        read_all(v); check("R5 pointer rewind", v, 40'h5544332299);
        cyc(1,1,ADR,8'h77,0,0,0,0,0);
        read_all(v); check("R5 read plus write", v, 40'h5544332277);

        for (int i = 0; i < 5; i++) wrb(8'h00);
        read_all(v); check("R10 zero writes", v, 40'h0);

        wrb(8'h34); wrb(8'h12);
        read_all(v); check("R4 partial load", v, 40'h1234);

        res(2'd0, 40'h100); idle(); res(2'd1, 40'h1); idle();
        read_all(v); check("R6 mul div add", v, 40'h1335);

        res(2'd2, 40'hFFFF); idle(); res(2'd3, 40'h77); idle();
        read_all(v); check("R7 shift normalize", v, 40'h1335);

        cyc(1,0,ADR,8'h00,1,2'd0,40'h20,0,0);
        #1; check("R8 write first", 40'(rd_data), 40'h00);
        idle();
        read_all(v); check("R8 deferred add", v, 40'h1320);

        cyc(0,0,ADR,0,0,0,0,1,0);
        read_all(v); check("R9 clr_mode", v, 40'h0);

        for (int i = 0; i < 5; i++) wrb(8'hFF);
        res(2'd0, 40'h2); idle();
        check("R6 overflow flag", 40'(ovf), 40'h1);
        read_all(v); check("R6 wrap", v, 40'h1);

        wrb(8'h5A);
        cyc(0,0,ADR,0,0,0,0,0,1);
        #1; check("R9 clr_start ovf", 40'(ovf), 40'h0);
        wrb(8'hAB);
        read_all(v); check("R9 pointer cleared", v, 40'hAB);

        cyc(1,0,ADR,8'h01,1,2'd1,40'h5,1,0);
        idle();
        read_all(v); check("R9 pending dropped", v, 40'h0);

        prev_rv = 0;
        for (int n = 0; n < 4000; n++) begin
            bit w, r, rv, cm, cs;
            logic [7:0] a;
            w  = ($urandom % 4) == 0;
            r  = ($urandom % 3) == 0;
            a  = (($urandom % 10) == 0) ? 8'($urandom) : ADR;
            rv = !prev_rv && !m_def && (($urandom % 3) == 0);
            cm = ($urandom % 97) == 0;
            cs = ($urandom % 89) == 0;
            cyc(w, r, a, 8'($urandom), rv, 2'($urandom),
                {8'($urandom), 32'($urandom)}, cm, cs);
            prev_rv = rv;
        end
        idle();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule